// File: doc/BRIEF.md
# Multi-Channel Timer with PWM, Edge Capture and Carrier Gating

A 16-bit up-counter that advances on ticks from a selectable clock divider and returns to zero at a programmable limit. It serves five independent channels. Each channel either produces a pulse-width waveform from its own 16-bit threshold or latches the counter value when a chosen edge arrives on its input.

In carrier mode the counter no longer advances on divider ticks. It steps once for every period of an external 8-bit carrier timer, which is signalled by a one-cycle pulse. Every channel waveform is then ANDed with that timer's carrier level, so the block emits a modulated infrared burst pattern without software involvement.

Software programs the block through a simple write strobe and an address. Read data for the same address is returned combinationally. Pin multiplexing and the carrier timer itself lie outside the block.

Top module: `irtmr_top`

## Requirements
- R1: After reset, CONTROL (address 0) reads 0, LIMIT (address 1) reads 0xFFFF, COUNT (address 2) reads 0, every channel output and irq are 0. The count rises by one per tick while CONTROL bit 0 (run) is 1, and holds while run is 0.
- R2: On a tick where the count is greater than or equal to LIMIT, the count becomes 0 and the wrap flag (STATUS address 3, bit 0) is set.
- R3: CONTROL bits [2:1] select the divider: 0 gives /1, 1 gives /8, 2 gives /32, 3 gives /128. A run lasting T clock edges yields floor(T/divide) ticks, because the divider restarts from zero on each run.
- R4: A channel whose config bit 0 is 0 drives its output high while COUNT is below its threshold and low otherwise. A threshold of 0 therefore holds the output low.
- R5: A channel whose config bit 0 is 1 is in capture mode. Config bits [2:1] choose the edge: 1 selects rising, 2 selects falling, 3 selects both, 0 selects none. A selected edge on the input, after two synchronising flops, copies COUNT into the channel value register and sets STATUS bit 1+k.
- R6: Edges that are not selected leave both the value and the flag unchanged. A channel in capture mode drives its output low.
- R7: When CONTROL bit 3 (carrier mode) is set, the count advances once per carrier_wrap pulse while run is 1, and divider ticks are ignored.
- R8: In carrier mode every channel output equals its waveform ANDed with carrier_in.
- R9: Writing 1 to a STATUS bit clears that bit, and writing 0 leaves it alone. irq is the OR of all STATUS bits.
- R10: Channel k has its config at address 4+2k and its value (threshold or captured count) at address 5+2k. COUNT is read-only, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for writes and reads |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr |
| carrier_in | input | 1 | Carrier waveform from the companion timer |
| carrier_wrap | input | 1 | One-cycle pulse per companion timer period |
| cap_in | input | 5 | Per-channel capture inputs (asynchronous) |
| ch_out | output | 5 | Per-channel waveform outputs |
| irq | output | 1 | Interrupt, OR of all status flags |

## Verification
The embedded assertions check the following on every cycle:
- The counter holds without a tick, steps by one on a tick, and lands on zero after a wrap.
- The divider never fires on consecutive cycles at divisions above one.
- A qualified edge always stores the previous cycle's count and raises the flag.
- Capture-mode channels and carrier-low cycles in carrier mode never drive an output.

Only the bench scenarios show the following:
- The tick counts for each divider and for carrier pulses.
- The wrap position under random limits and run lengths.
- Threshold comparison across random values.
- Edge-selection filtering and write-one-to-clear behaviour.

// File: rtl/irtmr_pkg.sv
package irtmr_pkg;
  typedef enum logic [1:0] {
    PS_DIV1   = 2'd0,
    PS_DIV8   = 2'd1,
    PS_DIV32  = 2'd2,
    PS_DIV128 = 2'd3
  } psel_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  localparam int ADR_CONTROL = 0;
  localparam int ADR_LIMIT   = 1;
  localparam int ADR_COUNT   = 2;
  localparam int ADR_STATUS  = 3;
  localparam int ADR_CH_BASE = 4;

  localparam int CTL_RUN  = 0;
  localparam int CTL_IR   = 3;
endpackage

// File: rtl/irtmr_prescale.sv
module irtmr_prescale
  import irtmr_pkg::*;
#(
  parameter int PRE_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pc_q, pc_d, mask;

  always_comb begin
    case (psel_e'(sel))
      PS_DIV1:  mask = '0;
      PS_DIV8:  mask = PRE_W'(7);
      PS_DIV32: mask = PRE_W'(31);
      default:  mask = PRE_W'(127);
    endcase
    tick = run && ((pc_q & mask) == mask);
    pc_d = run ? pc_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R3: above divide-by-one, ticks are never adjacent while sel is steady
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != 2'd0) |=> (!tick || sel != $past(sel)));
endmodule

// File: rtl/irtmr_counter.sv
module irtmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wrap  = tick && (cnt_q >= limit);
    cnt_d = cnt_q;
    if (tick) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R1: no tick, no movement
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> count == $past(count));
  // R1: a tick below the limit steps by one
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> count == $past(count) + 1'b1);
  // R2: a wrap lands on zero
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == '0);
endmodule

// File: rtl/irtmr_channel.sv
module irtmr_channel
  import irtmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_mode,
  input  logic [1:0]       edge_sel,
  input  logic             wr_val,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] count,
  input  logic             cap_in,
  input  logic             ir_en,
  input  logic             carrier,
  input  logic             clr_flag,
  output logic             out,
  output logic [CNT_W-1:0] value,
  output logic             flag
);
  logic             sync1_q, sync2_q, prev_q;
  logic [CNT_W-1:0] val_q, val_d;
  logic             flag_q, flag_d;
  logic             rise, fall, hit, pwm;

  always_comb begin
    rise = sync2_q && !prev_q;
    fall = !sync2_q && prev_q;
    case (edge_e'(edge_sel))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise || fall;
      default:   hit = 1'b0;
    endcase
    hit    = hit && cap_mode;
    val_d  = hit ? count : (wr_val ? wdata : val_q);
    flag_d = hit ? 1'b1 : (clr_flag ? 1'b0 : flag_q);
    pwm    = !cap_mode && (count < val_q);
    out    = pwm && (!ir_en || carrier);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      val_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      sync1_q <= cap_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      val_q   <= val_d;
      flag_q  <= flag_d;
    end
  end

  assign value = val_q;
  assign flag  = flag_q;

  // R5: a qualified edge stores the count seen on that cycle and raises the flag
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (value == $past(count)) && flag);
endmodule

// File: rtl/irtmr_top.sv
module irtmr_top
  import irtmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 5,
  parameter int PRE_W  = 7,
  localparam int ADDR_W = $clog2(ADR_CH_BASE + 2 * NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              carrier_in,
  input  logic              carrier_wrap,
  input  logic [NUM_CH-1:0] cap_in,
  output logic [NUM_CH-1:0] ch_out,
  output logic              irq
);
  localparam int ST_W = NUM_CH + 1;

  logic rs1_q, rs2_q, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_int_n = rs2_q;

  logic                   run_q, run_d, ir_q, ir_d;
  logic [1:0]             psel_q, psel_d;
  logic [CNT_W-1:0]       lim_q, lim_d;
  logic [NUM_CH-1:0][2:0] cfg_q, cfg_d;
  logic                   ovf_q, ovf_d;
  logic                   wr_ctl, wr_lim, wr_st;
  logic [ST_W-1:0]        clr;
  logic                   pre_tick, tick, wrap;
  logic [CNT_W-1:0]       count;
  logic [NUM_CH-1:0]      cap_flag, wr_val;
  logic [CNT_W-1:0]       ch_val [NUM_CH];

  always_comb begin
    wr_ctl = wr_en && (addr == ADDR_W'(ADR_CONTROL));
    wr_lim = wr_en && (addr == ADDR_W'(ADR_LIMIT));
    wr_st  = wr_en && (addr == ADDR_W'(ADR_STATUS));
    clr    = wr_st ? wdata[ST_W-1:0] : '0;
    run_d  = wr_ctl ? wdata[CTL_RUN]   : run_q;
    ir_d   = wr_ctl ? wdata[CTL_IR]    : ir_q;
    psel_d = wr_ctl ? wdata[2:1]       : psel_q;
    lim_d  = wr_lim ? wdata            : lim_q;
    ovf_d  = wrap ? 1'b1 : (clr[0] ? 1'b0 : ovf_q);
    cfg_d  = cfg_q;
    for (int k = 0; k < NUM_CH; k++) begin
      if (wr_en && addr == ADDR_W'(ADR_CH_BASE + 2 * k)) cfg_d[k] = wdata[2:0];
      wr_val[k] = wr_en && (addr == ADDR_W'(ADR_CH_BASE + 2 * k + 1));
    end
    tick = run_q && (ir_q ? carrier_wrap : pre_tick);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      run_q  <= 1'b0;
      ir_q   <= 1'b0;
      psel_q <= 2'd0;
      lim_q  <= '1;
      cfg_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      ir_q   <= ir_d;
      psel_q <= psel_d;
      lim_q  <= lim_d;
      cfg_q  <= cfg_d;
      ovf_q  <= ovf_d;
    end
  end

  irtmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_int_n), .run(run_q && !ir_q), .sel(psel_q), .tick(pre_tick)
  );

  irtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .limit(lim_q), .count(count), .wrap(wrap)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    irtmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_int_n),
      .cap_mode(cfg_q[k][0]), .edge_sel(cfg_q[k][2:1]),
      .wr_val(wr_val[k]), .wdata(wdata), .count(count),
      .cap_in(cap_in[k]), .ir_en(ir_q), .carrier(carrier_in),
      .clr_flag(clr[k+1]),
      .out(ch_out[k]), .value(ch_val[k]), .flag(cap_flag[k])
    );

    // R6: a capture channel never drives its output
    a_r6_capture_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
      cfg_q[k][0] |-> !ch_out[k]);
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(ADR_CONTROL): rdata = CNT_W'({ir_q, psel_q, run_q});
      ADDR_W'(ADR_LIMIT):   rdata = lim_q;
      ADDR_W'(ADR_COUNT):   rdata = count;
      ADDR_W'(ADR_STATUS):  rdata = CNT_W'({cap_flag, ovf_q});
      default: begin
        for (int k = 0; k < NUM_CH; k++) begin
          if (addr == ADDR_W'(ADR_CH_BASE + 2 * k))     rdata = CNT_W'(cfg_q[k]);
          if (addr == ADDR_W'(ADR_CH_BASE + 2 * k + 1)) rdata = ch_val[k];
        end
      end
    endcase
  end

  assign irq = ovf_q || (|cap_flag);

  // R2: a wrap always leaves the wrap flag set
  a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_int_n)
    wrap |=> ovf_q);
  // R8: in carrier mode a low carrier silences every channel
  a_r8_carrier_gate: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ir_q && !carrier_in) |-> ch_out == '0);
  // R7: in carrier mode the count moves only on a carrier pulse
  a_r7_carrier_only: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ir_q && !carrier_wrap) |=> $stable(count));
endmodule

// File: tb/irtmr_top_test.sv
module irtmr_top_test;
  localparam int CLK_P = 10;
  localparam int NCH = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        carrier_in = 1'b0;
  logic        carrier_wrap = 1'b0;
  logic [NCH-1:0] cap_in = '0;
  logic [NCH-1:0] ch_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_cnt = 16'd0;
  logic [15:0] m_lim = 16'hFFFF;
  bit          m_wrap = 0;
  logic [15:0] cmp [NCH];
  logic [15:0] d;
  logic [15:0] cap_val;

  always #(CLK_P/2) clk = ~clk;

  irtmr_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .carrier_in(carrier_in), .carrier_wrap(carrier_wrap),
    .cap_in(cap_in), .ch_out(ch_out), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = v;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk);
    addr = 4'(a);
    #1 v = rdata;
  endtask

  task automatic model_adv(input int ticks);
    for (int i = 0; i < ticks; i++) begin
      if (m_cnt >= m_lim) begin m_cnt = 16'd0; m_wrap = 1; end
      else m_cnt = m_cnt + 16'd1;
    end
  endtask

  // run for K+1 clock edges with the given control word, then stop
  task automatic run_for(input logic [15:0] ctl, input int k);
    wr(0, ctl);
    repeat (k) @(posedge clk);
    wr(0, ctl & 16'hFFFE);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5));
    for (int k = 0; k < NCH; k++) cmp[k] = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_n(4);

    // R1 reset state
    rd(0, d); chk(d == 16'd0, "R1 control after reset", d, 0);
    rd(1, d); chk(d == 16'hFFFF, "R1 limit after reset", d, 16'hFFFF);
    rd(2, d); chk(d == 16'd0, "R1 count after reset", d, 0);
    rd(3, d); chk(d == 16'd0, "R9 status after reset", d, 0);
    chk(ch_out == '0 && irq == 1'b0, "R1 outputs after reset", {ch_out, irq}, 0);

    // R1 R2 R4: random limits, run lengths and thresholds
    for (int it = 0; it < 10; it++) begin
      m_lim = 16'(3 + $urandom % 38);
      wr(1, m_lim);
      for (int k = 0; k < NCH; k++) begin
        cmp[k] = 16'($urandom % 46);
        wr(5 + 2 * k, cmp[k]);
      end
      wr(3, 16'h3F);
      m_wrap = 0;
      begin
        int kk = int'($urandom % 60);
        run_for(16'h0001, kk);
        model_adv(kk + 1);
      end
      rd(2, d); chk(d == m_cnt, "R1 R2 count after run", d, m_cnt);
      rd(3, d); chk(d[0] == m_wrap, "R2 wrap flag", d[0], m_wrap);
      chk(irq == m_wrap, "R9 irq follows wrap flag", irq, m_wrap);
      for (int k = 0; k < NCH; k++)
        chk(ch_out[k] == (m_cnt < cmp[k]), "R4 waveform vs threshold", ch_out[k], (m_cnt < cmp[k]));
    end

    // R4: threshold 0 stays low
    wr(5, 16'd0);
    for (int j = 0; j < 3; j++) begin
      run_for(16'h0001, j);
      model_adv(j + 1);
      chk(ch_out[0] == 1'b0, "R4 zero threshold low", ch_out[0], 0);
    end

    // R3: divider selections
    m_lim = 16'hFFFF; wr(1, m_lim);
    for (int s = 0; s < 4; s++) begin
      int dv;
      dv = (s == 0) ? 1 : (s == 1) ? 8 : (s == 2) ? 32 : 128;
      run_for(16'(s << 1) | 16'h0001, 299);
      model_adv(300 / dv);
      rd(2, d); chk(d == m_cnt, "R3 divider tick count", d, m_cnt);
    end

    // R7: carrier mode counts only carrier pulses
    run_for(16'h0009, 20);
    rd(2, d); chk(d == m_cnt, "R7 no carrier pulse no count", d, m_cnt);
    wr(0, 16'h0009);
    for (int p = 0; p < 6; p++) begin
      @(negedge clk) carrier_wrap = 1'b1;
      @(negedge clk) carrier_wrap = 1'b0;
      wait_n(2);
    end
    wr(0, 16'h0008);
    model_adv(6);
    rd(2, d); chk(d == m_cnt, "R7 carrier pulse count", d, m_cnt);

    // R8: carrier gating
    wr(4, 16'd0);
    wr(5, m_cnt + 16'd1);
    wr(7, 16'd0);
    carrier_in = 1'b0; wait_n(1); #1;
    chk(ch_out[0] == 1'b0, "R8 carrier low gates output", ch_out[0], 0);
    carrier_in = 1'b1; wait_n(1); #1;
    chk(ch_out[0] == 1'b1, "R8 carrier high passes output", ch_out[0], 1);
    chk(ch_out[1] == 1'b0, "R4 zero threshold in carrier mode", ch_out[1], 0);
    wr(0, 16'h0000);
    carrier_in = 1'b0;

    // R5: rising capture on channel 2
    wr(3, 16'h3F);
    wr(8, 16'h0003);
    cap_in[2] = 1'b1;
    wait_n(5);
    rd(9, d); chk(d == m_cnt, "R5 rising capture value", d, m_cnt);
    cap_val = m_cnt;
    rd(3, d); chk(d[3] == 1'b1, "R5 capture flag", d[3], 1);
    chk(irq == 1'b1, "R9 irq on capture", irq, 1);
    chk(ch_out[2] == 1'b0, "R6 capture channel quiet", ch_out[2], 0);

    // R6: falling edge ignored with rising-only selection
    run_for(16'h0001, 4);
    model_adv(5);
    wr(3, 16'h3F);
    cap_in[2] = 1'b0;
    wait_n(5);
    rd(9, d); chk(d == cap_val, "R6 unselected edge keeps value", d, cap_val);
    rd(3, d); chk(d[3] == 1'b0, "R6 unselected edge no flag", d[3], 0);

    // R5: both edges
    wr(8, 16'h0007);
    cap_in[2] = 1'b1;
    wait_n(5);
    rd(9, d); chk(d == m_cnt, "R5 both-edge rising capture", d, m_cnt);
    wr(3, 16'h3F);
    run_for(16'h0001, 2);
    model_adv(3);
    cap_in[2] = 1'b0;
    wait_n(5);
    rd(9, d); chk(d == m_cnt, "R5 both-edge falling capture", d, m_cnt);
    rd(3, d); chk(d[3] == 1'b1, "R5 falling flag", d[3], 1);

    // R9: write 0 keeps, write 1 clears
    wr(3, 16'h0000);
    rd(3, d); chk(d[3] == 1'b1, "R9 write zero keeps flag", d[3], 1);
    wr(3, 16'h0008);
    rd(3, d); chk(d == 16'd0, "R9 write one clears flag", d, 0);
    chk(irq == 1'b0, "R9 irq clears", irq, 0);

    // R10: count is read-only
    wr(2, 16'(m_cnt + 16'd77));
    rd(2, d); chk(d == m_cnt, "R10 count write ignored", d, m_cnt);
    rd(8, d); chk(d == 16'h0007, "R10 config readback", d, 7);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule